// File: doc/BRIEF.md
# Boot Address Reset Controller

This block decides where the processor begins fetching after a reset and produces the processor's reset. It holds one boot address register behind a small write/read port. Software writes the entry point of a freshly loaded program into it. That value does not move the processor at once. It becomes the launch address presented to the core only while the core is held in reset, so the next reset starts the new program.

A bootloader request input returns the stored address to the boot ROM base. This way a board button can always recover the loader. A raw reset input is synchronised into the processor reset. A separate power-on reset clears the register. Later processor resets leave the register as it is.

One compile-time parameter picks the reset style for the build. The FPGA style uses active-low resets sampled on the clock. The ASIC style uses active-high resets that act without the clock. The processor reset output uses the same polarity as the reset inputs.

Top module: `boot_rst_ctrl`

## Requirements
- R1: While power-on reset is active, the stored address and the launch address both equal the boot ROM base (default 0x0000_1000), and the processor reset output is active.
- R2: A write (wr_en_i high at a clock edge, no bootloader request) stores wr_data_i with bits [1:0] cleared. The stored value is visible on rd_data_o after that edge. rd_data_o bits [1:0] always read 0.
- R3: While the processor reset output stays inactive, the launch address does not change, whatever is written or requested.
- R4: While the processor reset output is active, the launch address follows the stored address. After reset release it holds the last value captured.
- R5: A bootloader request at a clock edge sets the stored address to the boot ROM base.
- R6: When a bootloader request and a write occur at the same edge, the stored address becomes the boot ROM base and the write is dropped.
- R7: A raw (non power-on) reset leaves the stored address unchanged. Only power-on reset returns it to the base.
- R8: The processor reset output goes inactive exactly two clock edges after both reset inputs become inactive. The edge that first samples the released input counts as the first of the two.
- R9: With TGT_ASIC=0, resets are active-low and take effect at the next clock edge: the processor reset output is not active before that edge. With TGT_ASIC=1, resets are active-high and act without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, polarity set by TGT_ASIC |
| rst_raw_i | input | 1 | Raw processor reset request, polarity set by TGT_ASIC |
| boot_req_i | input | 1 | Bootloader request, active-high, returns the stored address to the ROM base |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | ADDR_W | Entry point to store |
| rd_data_o | output | ADDR_W | Currently stored boot address |
| boot_addr_o | output | ADDR_W | Launch address presented to the processor |
| cpu_rst_o | output | 1 | Synchronised processor reset, same polarity as the reset inputs |

## Verification
The hardest case to reach is the hand-over from the stored address to the launch address. It needs a write while the core runs, a check that the launch address has not moved, and then a raw reset pulse long enough for the capture. After release the launch address must stay frozen while the register is rewritten. The stimulus chains these steps in order. It then asserts a raw reset, checks before the next edge that the output has not yet responded, and counts the edges to release. A last power-on pulse shows that only that reset clears a stored entry point.

// File: rtl/boot_rst_pkg.sv
package boot_rst_pkg;
  localparam int ALIGN_BITS = 2;

  // Convert a raw reset pin level into an active-high request.
  function automatic logic rst_level_active(input bit asic_style, input logic pin);
    return asic_style ? pin : ~pin;
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2,
  parameter bit ASYNC  = 1'b0
) (
  input  logic clk_i,
  input  logic rst_req_i,   // active-high
  output logic rst_hold_o   // active-high, release aligned to clk_i
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b0};

  generate
    if (ASYNC) begin : g_async
      always_ff @(posedge clk_i or posedge rst_req_i) begin
        if (rst_req_i) chain_q <= '1;
        else           chain_q <= chain_d;
      end
    end else begin : g_sync
      always_ff @(posedge clk_i) begin
        if (rst_req_i) chain_q <= '1;
        else           chain_q <= chain_d;
      end
    end
  endgenerate

  assign rst_hold_o = chain_q[STAGES-1];
endmodule

// File: rtl/boot_addr_store.sv
module boot_addr_store
  import boot_rst_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 32'h0000_1000,
  parameter bit                ASYNC     = 1'b0
) (
  input  logic              clk_i,
  input  logic              por_i,       // active-high
  input  logic              boot_req_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              cpu_in_rst_i,
  output logic [ADDR_W-1:0] stored_o,
  output logic [ADDR_W-1:0] launch_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'((1 << ALIGN_BITS) - 1));
  localparam logic [ADDR_W-1:0] BASE_AL    = BOOT_BASE & ALIGN_MASK;

  logic [ADDR_W-1:0] store_q, store_d;
  logic [ADDR_W-1:0] launch_q, launch_d;

  always_comb begin
    store_d = store_q;
    if (boot_req_i)   store_d = BASE_AL;          // request outranks a write
    else if (wr_en_i) store_d = wr_data_i & ALIGN_MASK;
    launch_d = cpu_in_rst_i ? store_q : launch_q;
  end

  generate
    if (ASYNC) begin : g_async
      always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
          store_q  <= BASE_AL;
          launch_q <= BASE_AL;
        end else begin
          store_q  <= store_d;
          launch_q <= launch_d;
        end
      end
    end else begin : g_sync
      always_ff @(posedge clk_i) begin
        if (por_i) begin
          store_q  <= BASE_AL;
          launch_q <= BASE_AL;
        end else begin
          store_q  <= store_d;
          launch_q <= launch_d;
        end
      end
    end
  endgenerate

  assign stored_o = store_q;
  assign launch_o = launch_q;
endmodule

// File: rtl/boot_rst_ctrl.sv
module boot_rst_ctrl
  import boot_rst_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] BOOT_BASE   = 32'h0000_1000,
  parameter bit                TGT_ASIC    = 1'b0,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              rst_raw_i,
  input  logic              boot_req_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] boot_addr_o,
  output logic              cpu_rst_o
);
  logic por_act, raw_act, rst_any, cpu_hold;

  always_comb begin
    por_act = rst_level_active(TGT_ASIC, por_i);
    raw_act = rst_level_active(TGT_ASIC, rst_raw_i);
    rst_any = por_act | raw_act;
  end

  rst_sync #(
    .STAGES (SYNC_STAGES),
    .ASYNC  (TGT_ASIC)
  ) u_sync (
    .clk_i      (clk_i),
    .rst_req_i  (rst_any),
    .rst_hold_o (cpu_hold)
  );

  boot_addr_store #(
    .ADDR_W    (ADDR_W),
    .BOOT_BASE (BOOT_BASE),
    .ASYNC     (TGT_ASIC)
  ) u_store (
    .clk_i        (clk_i),
    .por_i        (por_act),
    .boot_req_i   (boot_req_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .cpu_in_rst_i (cpu_hold),
    .stored_o     (rd_data_o),
    .launch_o     (boot_addr_o)
  );

  assign cpu_rst_o = TGT_ASIC ? cpu_hold : ~cpu_hold;
endmodule

// File: rtl/boot_rst_ctrl_chk.sv
module boot_rst_ctrl_chk #(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 32'h0000_1000,
  parameter bit                TGT_ASIC  = 1'b0
) (
  input logic              clk_i,
  input logic              por_i,
  input logic              rst_raw_i,
  input logic              boot_req_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_data_i,
  input logic [ADDR_W-1:0] rd_data_o,
  input logic [ADDR_W-1:0] boot_addr_o,
  input logic              cpu_rst_o
);
  localparam logic [ADDR_W-1:0] MASK = ~(ADDR_W'(3));
  logic por_on, raw_on, cpu_on;
  assign por_on = TGT_ASIC ? por_i : ~por_i;
  assign raw_on = TGT_ASIC ? rst_raw_i : ~rst_raw_i;
  assign cpu_on = TGT_ASIC ? cpu_rst_o : ~cpu_rst_o;

  assert_rd_aligned_R2: assert property (@(posedge clk_i) disable iff (por_on)
    rd_data_o[1:0] == 2'b00);

  assert_write_store_R2: assert property (@(posedge clk_i) disable iff (por_on)
    (wr_en_i && !boot_req_i) |=> rd_data_o == ($past(wr_data_i) & MASK));

  assert_launch_hold_R3: assert property (@(posedge clk_i) disable iff (por_on)
    $past(!cpu_on) |-> $stable(boot_addr_o));

  assert_req_base_R5: assert property (@(posedge clk_i) disable iff (por_on)
    boot_req_i |=> rd_data_o == (BOOT_BASE & MASK));

  assert_req_wins_R6: assert property (@(posedge clk_i) disable iff (por_on)
    (boot_req_i && wr_en_i) |=> rd_data_o == (BOOT_BASE & MASK));

  assert_release_late_R8: assert property (@(posedge clk_i) disable iff (por_on)
    (!cpu_on && $past(cpu_on)) |-> (!$past(raw_on) && !$past(por_on)));
endmodule

bind boot_rst_ctrl boot_rst_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .BOOT_BASE (BOOT_BASE),
  .TGT_ASIC  (TGT_ASIC)
) u_chk (
  .clk_i       (clk_i),
  .por_i       (por_i),
  .rst_raw_i   (rst_raw_i),
  .boot_req_i  (boot_req_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .rd_data_o   (rd_data_o),
  .boot_addr_o (boot_addr_o),
  .cpu_rst_o   (cpu_rst_o)
);

// File: tb/boot_rst_ctrl_test.sv
`timescale 1ns/1ps
module boot_rst_ctrl_test;
  localparam int          AW   = 32;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic        ON   = 1'b0;   // FPGA style: active-low
  localparam logic        OFF  = 1'b1;

  typedef struct {
    string       tag;
    logic [31:0] rd;
    logic [31:0] boot;
    logic        rst_on;
  } exp_t;

  logic clk = 1'b0;
  logic por, raw, breq, wen;
  logic [AW-1:0] wdat, rd, boot;
  logic cpu_rst;
  int n_chk = 0, n_bad = 0;
  exp_t q[$];
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  boot_rst_ctrl #(.ADDR_W(AW), .BOOT_BASE(BASE), .TGT_ASIC(1'b0)) uut (
    .clk_i(clk), .por_i(por), .rst_raw_i(raw), .boot_req_i(breq),
    .wr_en_i(wen), .wr_data_i(wdat), .rd_data_o(rd),
    .boot_addr_o(boot), .cpu_rst_o(cpu_rst));

  // Monitor: pops one expectation at each falling edge and compares.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk += 3;
      if (rd !== e.rd) begin
        n_bad++; $display("FAIL %s rd_data act=%h exp=%h", e.tag, rd, e.rd);
      end
      if (boot !== e.boot) begin
        n_bad++; $display("FAIL %s boot_addr act=%h exp=%h", e.tag, boot, e.boot);
      end
      if ((cpu_rst === ON) !== e.rst_on) begin
        n_bad++; $display("FAIL %s cpu_rst act=%b exp_active=%b", e.tag, cpu_rst, e.rst_on);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_now(string tag, logic [31:0] r, logic [31:0] b, logic ron);
    exp_t e;
    e.tag = tag; e.rd = r; e.boot = b; e.rst_on = ron;
    q.push_back(e);
    @(negedge clk); #1;
  endtask

  initial begin
    por = ON; raw = OFF; breq = 0; wen = 0; wdat = '0;
    tick(); tick(); tick();
    expect_now("R1", BASE, BASE, 1);
    @(posedge clk); #1;
    por = OFF;
    tick(); expect_now("R8", BASE, BASE, 1);
    tick(); expect_now("R8", BASE, BASE, 0);

    wen = 1; wdat = 32'h0000_2003;
    tick(); wen = 0; expect_now("R2", 32'h0000_2000, BASE, 0);
    wen = 1; wdat = 32'h1234_5677;
    tick(); wen = 0; expect_now("R3", 32'h1234_5674, BASE, 0);

    @(posedge clk); #1;
    raw = ON;
    expect_now("R9", 32'h1234_5674, BASE, 0);
    tick(); expect_now("R9", 32'h1234_5674, BASE, 1);
    tick(); expect_now("R4", 32'h1234_5674, 32'h1234_5674, 1);
    @(posedge clk); #1;
    raw = OFF;
    tick(); expect_now("R8", 32'h1234_5674, 32'h1234_5674, 1);
    tick(); expect_now("R7", 32'h1234_5674, 32'h1234_5674, 0);

    wen = 1; wdat = 32'hAAAA_0001;
    tick(); wen = 0; expect_now("R3", 32'hAAAA_0000, 32'h1234_5674, 0);
    breq = 1;
    tick(); breq = 0; expect_now("R5", BASE, 32'h1234_5674, 0);
    wen = 1; wdat = 32'h0000_5550;
    tick(); wen = 0; expect_now("R2", 32'h0000_5550, 32'h1234_5674, 0);
    breq = 1; wen = 1; wdat = 32'h0000_7770;
    tick(); breq = 0; wen = 0; expect_now("R6", BASE, 32'h1234_5674, 0);

    wen = 1; wdat = 32'h0000_4000;
    tick(); wen = 0;
    @(posedge clk); #1;
    raw = ON;
    tick(); tick();
    @(posedge clk); #1;
    raw = OFF;
    tick(); tick(); expect_now("R4", 32'h0000_4000, 32'h0000_4000, 0);
    tick(); tick(); expect_now("R3", 32'h0000_4000, 32'h0000_4000, 0);

    @(posedge clk); #1;
    por = ON;
    tick(); expect_now("R7", BASE, BASE, 1);
    @(posedge clk); #1;
    por = OFF;
    tick(); tick(); expect_now("R1", BASE, BASE, 0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=completion");
    end
    #20;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule